// File: doc/BRIEF.md
# Interrupt CPU Interface with Acknowledge

This block is the per-processor side of an interrupt controller. It keeps an 8-bit priority and an enable for each interrupt source. It latches pending requests from peripheral lines and from software-generated-interrupt writes. Each cycle it picks the most urgent eligible request. While the interface is enabled, it raises a single interrupt line to the processor whenever a request qualifies.

Software takes an interrupt by reading the acknowledge register. That read returns the winning ID and, for software-generated IDs, the number of the processor that raised them. The same read moves the interrupt from pending to active. An active ID is not offered again until software writes the ID to the end-of-interrupt register. When nothing qualifies, the acknowledge read returns the spurious ID 1023 and changes no state. A priority threshold register blocks every request whose priority value is not strictly below it.

All register access uses a simple synchronous bus. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the request.

Top module: `irq_cpu_if`

Register offsets: control 0x00, threshold 0x04, acknowledge 0x08, end-of-interrupt 0x0C, software interrupt 0x10, enable-set 0x14, enable-clear 0x18, pending view 0x1C, active view 0x20, priority words from 0x40.

## Requirements
- R1: After reset, control reads 0 and the threshold reads 0. Every priority byte reads 0xA0. The enable view reads 0x0000FFFF (software IDs 0-15 enabled, the rest disabled). The acknowledge register reads 1023 and irq_out is low.
- R2: The priority of source n is the byte at bit 8*(n%4) of the word at offset 0x40+4*(n/4). A write stores all four bytes of the word, and reads return them in the same layout.
- R3: Among eligible requests (pending, enabled, not active), the lowest priority value wins. Ties go to the lowest ID.
- R4: A request qualifies only if its priority value is strictly below the threshold in bits 7:0 of offset 0x04. A request whose priority equals the threshold is not signalled.
- R5: Bit 0 of the control register gates the interface. With it clear, irq_out is low and an acknowledge read returns 1023 without changing pending or active state.
- R6: An acknowledge read with a qualifying request returns the ID in bits 9:0. For IDs 0-15 it also returns the requesting processor number in bits 12:10 (zero otherwise). The read clears that ID's pending bit and sets its active bit.
- R7: An acknowledge read with no qualifying request returns 1023 in bits 9:0 and leaves all state unchanged.
- R8: An active ID is never offered, even if it becomes pending again, until its end-of-interrupt.
- R9: Writing an ID in bits 9:0 to offset 0x0C clears that ID's active bit. An ID at or above the source count has no effect.
- R10: A write to offset 0x10 carries a target list in bits 23:16 and an ID in bits 3:0. It sets that ID pending only if the target bit of this interface (parameter MY_CPU, default 0) is set. When it does, the bus processor number bus_cpu is recorded as the requester.
- R11: A one-cycle high on hw_req[n] sets source n pending for n >= 16. Bits 0-15 of hw_req are ignored.
- R12: Writing ones to offset 0x14 sets enables, and writing ones to offset 0x18 clears them. Offset 0x14 reads back the enable vector. Offsets 0x1C and 0x20 read back the pending and active vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | NUM_SRC | Peripheral request pulses, one per source |
| bus_cpu | input | 3 | Number of the processor issuing the current write |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_en |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Every write and every hw_req pulse updates state at the clock edge that samples it. irq_out is derived combinationally from that state, so it is checked in the low phase of the following cycle. Read data, including the acknowledge result and its pending-to-active side effect, is registered on the edge that samples rd_en. The bench drives every strobe for exactly one cycle from a falling edge and samples rd_data and irq_out on the next falling edge. A reference model updated at the same points predicts each acknowledge word, so a back-to-back acknowledge sequence checks both the returned ID and the state that the previous read left behind.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int PRIO_W  = 8;
  localparam int CPU_W   = 3;
  localparam int SGI_NUM = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_PMR   = 8'h04;
  localparam logic [ADDR_W-1:0] A_ACK   = 8'h08;
  localparam logic [ADDR_W-1:0] A_EOI   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_SGI   = 8'h10;
  localparam logic [ADDR_W-1:0] A_ENSET = 8'h14;
  localparam logic [ADDR_W-1:0] A_ENCLR = 8'h18;
  localparam logic [ADDR_W-1:0] A_PEND  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ACT   = 8'h20;
  localparam logic [ADDR_W-1:0] A_PRIO  = 8'h40;

  localparam logic [9:0]        SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] PRIO_RST    = 8'hA0;
endpackage

// File: rtl/irq_cpu_if_prio.sv
module irq_cpu_if_prio
  import irq_cpu_if_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  // One byte per source; word w holds sources 4w..4w+3 at lane (n % 4).
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [ADDR_W-1:0] WORD_ADDR = A_PRIO + ADDR_W'(4 * (g / 4));
    localparam int                LANE      = g % 4;
    logic [PRIO_W-1:0] prio_q;
    always_ff @(posedge clk) begin
      if (rst)
        prio_q <= PRIO_RST;
      else if (wr_en && wr_addr == WORD_ADDR)
        prio_q <= wr_data[LANE*PRIO_W +: PRIO_W];
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/irq_cpu_if_arb.sv
module irq_cpu_if_arb
  import irq_cpu_if_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [PRIO_W-1:0]         pmr,
  output logic                      cand_valid,
  output logic [IDX_W-1:0]          cand_id
);
  logic [PRIO_W-1:0] best_prio;

  // Linear scan from ID 0 upward; strict compare keeps the lower ID on ties.
  always_comb begin
    cand_valid = 1'b0;
    cand_id    = '0;
    best_prio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && prio_flat[i*PRIO_W +: PRIO_W] < pmr &&
          (!cand_valid || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
        cand_valid = 1'b1;
        cand_id    = IDX_W'(i);
        best_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_cpu_if_state.sv
module irq_cpu_if_state
  import irq_cpu_if_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int MY_CPU  = 0,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       hw_req,
  input  logic                     sgi_wr,
  input  logic [7:0]               sgi_targets,
  input  logic [3:0]               sgi_id,
  input  logic [CPU_W-1:0]         sgi_cpu,
  input  logic                     ack_take,
  input  logic [IDX_W-1:0]         ack_id,
  input  logic                     eoi_wr,
  input  logic [9:0]               eoi_id,
  input  logic                     en_set_wr,
  input  logic                     en_clr_wr,
  input  logic [NUM_SRC-1:0]       en_bits,
  output logic [NUM_SRC-1:0]       pend,
  output logic [NUM_SRC-1:0]       act,
  output logic [NUM_SRC-1:0]       en,
  output logic [SGI_NUM*CPU_W-1:0] sgi_src_flat
);
  localparam logic [NUM_SRC-1:0] EN_RST = NUM_SRC'({SGI_NUM{1'b1}});
  localparam logic [NUM_SRC-1:0] HW_MASK = ~EN_RST;

  logic [NUM_SRC-1:0] pend_n, act_n, en_n;
  logic               sgi_hit;

  assign sgi_hit = sgi_wr && sgi_targets[MY_CPU];

  always_comb begin
    pend_n = pend;
    if (ack_take) pend_n[ack_id] = 1'b0;
    pend_n = pend_n | (hw_req & HW_MASK);
    if (sgi_hit) pend_n[sgi_id] = 1'b1;

    act_n = act;
    if (eoi_wr && int'(eoi_id) < NUM_SRC) act_n[eoi_id[IDX_W-1:0]] = 1'b0;
    if (ack_take) act_n[ack_id] = 1'b1;

    en_n = en;
    if (en_set_wr) en_n = en_n | en_bits;
    if (en_clr_wr) en_n = en_n & ~en_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      act  <= '0;
      en   <= EN_RST;
    end else begin
      pend <= pend_n;
      act  <= act_n;
      en   <= en_n;
    end
  end

  for (genvar s = 0; s < SGI_NUM; s++) begin : g_sgi
    logic [CPU_W-1:0] src_q;
    always_ff @(posedge clk) begin
      if (rst)
        src_q <= '0;
      else if (sgi_hit && sgi_id == 4'(s))
        src_q <= sgi_cpu;
    end
    assign sgi_src_flat[s*CPU_W +: CPU_W] = src_q;
  end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int MY_CPU  = 0,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int WORDS  = NUM_SRC / 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   hw_req,
  input  logic [CPU_W-1:0]     bus_cpu,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_out
);
  logic                      ctrl_en;
  logic [PRIO_W-1:0]         pmr;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        pend, act, en, elig;
  logic [SGI_NUM*CPU_W-1:0]  sgi_src_flat;
  logic                      cand_valid;
  logic [IDX_W-1:0]          cand_id;
  logic                      ack_rd, ack_take;
  logic [CPU_W-1:0]          ack_src;
  logic [DATA_W-1:0]         ack_word, prio_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      pmr     <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_en <= wr_data[0];
      if (wr_addr == A_PMR)  pmr     <= wr_data[PRIO_W-1:0];
    end
  end

  irq_cpu_if_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prio_flat(prio_flat)
  );

  assign elig = pend & en & ~act;

  irq_cpu_if_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .prio_flat(prio_flat), .elig(elig), .pmr(pmr),
    .cand_valid(cand_valid), .cand_id(cand_id)
  );

  assign irq_out  = ctrl_en && cand_valid;
  assign ack_rd   = rd_en && rd_addr == A_ACK;
  assign ack_take = ack_rd && irq_out;

  irq_cpu_if_state #(.NUM_SRC(NUM_SRC), .MY_CPU(MY_CPU)) u_state (
    .clk(clk), .rst(rst), .hw_req(hw_req),
    .sgi_wr(wr_en && wr_addr == A_SGI), .sgi_targets(wr_data[23:16]),
    .sgi_id(wr_data[3:0]), .sgi_cpu(bus_cpu),
    .ack_take(ack_take), .ack_id(cand_id),
    .eoi_wr(wr_en && wr_addr == A_EOI), .eoi_id(wr_data[9:0]),
    .en_set_wr(wr_en && wr_addr == A_ENSET),
    .en_clr_wr(wr_en && wr_addr == A_ENCLR),
    .en_bits(wr_data[NUM_SRC-1:0]),
    .pend(pend), .act(act), .en(en), .sgi_src_flat(sgi_src_flat)
  );

  // Requester number only for software-generated IDs.
  assign ack_src  = (int'(cand_id) < SGI_NUM) ?
                    sgi_src_flat[int'(cand_id)*CPU_W +: CPU_W] : '0;
  assign ack_word = irq_out ? DATA_W'({ack_src, 10'(cand_id)}) : DATA_W'(SPURIOUS_ID);

  always_comb begin
    prio_rd = '0;
    for (int w = 0; w < WORDS; w++)
      if (rd_addr == A_PRIO + ADDR_W'(4 * w)) prio_rd = prio_flat[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_CTRL:  rd_data <= DATA_W'(ctrl_en);
        A_PMR:   rd_data <= DATA_W'(pmr);
        A_ACK:   rd_data <= ack_word;
        A_ENSET: rd_data <= DATA_W'(en);
        A_PEND:  rd_data <= DATA_W'(pend);
        A_ACT:   rd_data <= DATA_W'(act);
        default: rd_data <= prio_rd;
      endcase
    end
  end
endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk
  import irq_cpu_if_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [DATA_W-1:0]         wr_data,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic                      irq_out,
  input logic                      ctrl_en,
  input logic [PRIO_W-1:0]         pmr,
  input logic                      cand_valid,
  input logic [IDX_W-1:0]          cand_id,
  input logic [NUM_SRC-1:0]        act,
  input logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  a_r4_below_mask: assert property (@(posedge clk) disable iff (rst)
    cand_valid |-> prio_flat[int'(cand_id)*PRIO_W +: PRIO_W] < pmr);

  a_r5_gate: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |-> !irq_out);

  a_r6_ack_to_active: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_ACK && irq_out) |=>
      (act[$past(cand_id)] && rd_data[9:0] == 10'($past(cand_id))));

  a_r7_spurious: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_ACK && !irq_out && !wr_en) |=>
      (rd_data[9:0] == SPURIOUS_ID && act == $past(act)));

  a_r8_active_held: assert property (@(posedge clk) disable iff (rst)
    cand_valid |-> !act[cand_id]);

  a_r9_eoi_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_EOI && int'(wr_data[9:0]) < NUM_SRC &&
     !(rd_en && rd_addr == A_ACK)) |=> !act[$past(wr_data[IDX_W-1:0])]);
endmodule

bind irq_cpu_if irq_cpu_if_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out),
  .ctrl_en(ctrl_en), .pmr(pmr), .cand_valid(cand_valid), .cand_id(cand_id),
  .act(act), .prio_flat(prio_flat)
);

// File: tb/tb_irq_cpu_if.sv
module tb_irq_cpu_if;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] hw_req = '0;
  logic [2:0]  bus_cpu = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_out;

  irq_cpu_if #(.NUM_SRC(N), .MY_CPU(0)) dut (
    .clk(clk), .rst(rst), .hw_req(hw_req), .bus_cpu(bus_cpu),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [N-1:0] m_pend, m_act, m_en;
  logic [7:0]   m_prio [N];
  logic [7:0]   m_pmr;
  logic         m_ctrl;
  logic [2:0]   m_src [16];

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic int pick();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && !m_act[i] && m_prio[i] < m_pmr)
        if (best < 0 || m_prio[i] < m_prio[best]) best = i;
    return m_ctrl ? best : -1;
  endfunction

  function automatic logic [31:0] exp_ack();
    int p = pick();
    if (p < 0) return 32'd1023;
    return (p < 16) ? {19'd0, m_src[p], 10'(p)} : 32'(p);
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    case (a)
      8'h00: m_ctrl = d[0];
      8'h04: m_pmr = d[7:0];
      8'h0C: if (d[9:0] < N) m_act[d[4:0]] = 1'b0;
      8'h10: if (d[16]) begin m_pend[d[3:0]] = 1'b1; m_src[d[3:0]] = bus_cpu; end
      8'h14: m_en = m_en | d;
      8'h18: m_en = m_en & ~d;
      default: if (a >= 8'h40 && a < 8'h60)
        for (int k = 0; k < 4; k++) m_prio[(a - 8'h40) + k] = d[8*k +: 8];
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic ack(string req);
    logic [31:0] e, d;
    int p;
    e = exp_ack(); p = pick();
    rd(8'h08, d);
    check(req, d, e);
    if (p >= 0) begin m_pend[p] = 1'b0; m_act[p] = 1'b1; end
  endtask

  task automatic pulse(int id);
    @(negedge clk); hw_req[id] = 1'b1;
    @(negedge clk); hw_req = '0;
    if (id >= 16) m_pend[id] = 1'b1;
  endtask

  task automatic chk_irq(string req);
    @(negedge clk);
    check(req, 32'(irq_out), 32'(pick() >= 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    m_pend = '0; m_act = '0; m_en = 32'h0000FFFF; m_pmr = 0; m_ctrl = 0;
    for (int i = 0; i < N; i++) m_prio[i] = 8'hA0;
    for (int i = 0; i < 16; i++) m_src[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 pmr", d, 0);
    rd(8'h4C, d); check("R1 prio", d, 32'hA0A0A0A0);
    rd(8'h14, d); check("R1 enable", d, 32'h0000FFFF);
    ack("R1 ack");
    check("R1 irq", 32'(irq_out), 0);

    // R2 byte lanes
    wr(8'h50, 32'h40302010);
    rd(8'h50, d); check("R2 readback", d, 32'h40302010);
    wr(8'h14, 32'h00FF0000);
    wr(8'h04, 32'hF0); wr(8'h00, 1);
    pulse(18); pulse(17);
    chk_irq("R5 irq on");
    ack("R3 prio pick 17");
    // R8 17 active, pend again: 18 comes first, then nothing
    pulse(17);
    ack("R8 skip active 18");
    ack("R8 spurious while 17 active");
    wr(8'h0C, 32'd1000);
    rd(8'h20, d); check("R9 bad id ignored", d, m_act);
    wr(8'h0C, 32'd17);
    rd(8'h20, d); check("R9 eoi clears", d, m_act);
    ack("R8 reoffer after eoi");
    wr(8'h0C, 32'd17); wr(8'h0C, 32'd18);

    // R3 tie goes to lower id
    wr(8'h54, 32'h50505050);
    pulse(23); pulse(21);
    ack("R3 tie 21");
    // R4 threshold equal blocks
    wr(8'h04, 32'h50);
    ack("R4 equal blocked");
    chk_irq("R4 irq low");
    wr(8'h04, 32'hF0);
    // R5 disabled interface
    wr(8'h00, 0);
    chk_irq("R5 irq off");
    ack("R5 ack spurious");
    rd(8'h1C, d); check("R5 pending kept", d, m_pend);
    wr(8'h00, 1);
    ack("R3 remaining 23");
    // R12 enable clear
    wr(8'h0C, 21); wr(8'h0C, 23);
    pulse(19);
    wr(8'h18, 32'h00080000);
    rd(8'h14, d); check("R12 enable view", d, m_en);
    ack("R12 disabled not offered");
    wr(8'h14, 32'h00080000);
    ack("R12 reenabled 19");
    wr(8'h0C, 19);

    // R10 software interrupts
    bus_cpu = 3'd6;
    wr(8'h10, 32'h00010005);
    ack("R10 R6 sgi with source");
    wr(8'h10, 32'h00020007);
    rd(8'h1C, d); check("R10 other target", d, m_pend);
    wr(8'h0C, 5);
    // R11 low hw lines ignored
    pulse(3);
    rd(8'h1C, d); check("R11 hw low ignored", d, m_pend);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: pulse($urandom_range(16, N - 1));
        2: begin bus_cpu = 3'($urandom); wr(8'h10, {8'h0, 8'($urandom_range(0,3)), 12'h0, 4'($urandom)}); end
        3: wr(8'h40 + 8'(4 * $urandom_range(0, 7)), $urandom);
        4, 5: ack("R6 random ack");
        6: wr(8'h0C, $urandom_range(0, N - 1));
        7: wr(8'h14, $urandom);
        8: wr(8'h18, $urandom & 32'h0000_0F0F);
        default: wr(8'h04, ($urandom_range(0, 1) != 0) ? 32'hFF : 32'hC0);
      endcase
      if (it % 20 == 0) chk_irq("R3 random irq");
    end
    rd(8'h20, d); check("R6 final active", d, m_act);
    rd(8'h1C, d); check("R6 final pending", d, m_pend);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule